// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the internal address stream for a synchronous burst memory. A start strobe captures a full external address. After that, each advance cycle walks the two least significant address bits through a four-beat group, and the upper bits stay as they were captured. The beat order is either linear or interleaved. A static mode input picks between them.

Two active-low start strobes exist. The controller strobe always loads. The processor strobe loads only while the active-low primary chip enable is low. Either strobe may cut into a burst that is in progress, and the beat count then restarts at zero. The advance strobe is active low. Holding it high stalls the sequence, which gives wait states. On the clock edge that directly follows a processor-strobe load, an advance request is ignored. This keeps the captured address in place for a write that follows.

The current address is produced combinationally from registered state, so it changes right after the clock edge that loads or advances. Two one-cycle flags show which event happened on that edge. All pins are plain control pins. No streamed data crosses the block, so there is no valid/ready handshake.

Top module: `burst_addr_seq`

## Requirements
- R1: With `order_il` = 0 (linear), the two low bits of `cur_addr` equal (captured low bits + beat count) modulo 4. Example: start 01 gives 01, 10, 11, 00.
- R2: With `order_il` = 1 (interleaved), the two low bits of `cur_addr` equal (captured low bits XOR beat count). Example: start 10 gives 10, 11, 00, 01.
- R3: Bits above bit 1 of `cur_addr` keep the value captured at the last load until the next load.
- R4: If `ctl_start_n` is low at a clock edge, the block loads `ext_addr` whatever the chip enable is, even in the middle of a burst. After that edge `cur_addr` equals `ext_addr` and the beat count is zero.
- R5: If `cpu_start_n` is low and `chip_en_n` is low at an edge, the block loads the same way as R4. If `chip_en_n` is high, `cpu_start_n` has no effect.
- R6: When no load occurs, `adv_n` low at an edge moves to the next beat. `adv_n` high keeps `cur_addr` unchanged.
- R7: On the edge right after a load taken through `cpu_start_n`, the beat does not advance even if `adv_n` is low.
- R8: After the fourth beat, further advances keep wrapping within the same four-beat group.
- R9: While `rst_n` is low and right after it, `cur_addr` is 0 and both flags are 0.
- R10: `loaded` is high for exactly the cycle after a load edge. `advanced` is high for exactly the cycle after an advance edge. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | External address captured on a load |
| cpu_start_n | input | 1 | Processor start strobe, active low, gated by chip enable |
| ctl_start_n | input | 1 | Controller start strobe, active low |
| chip_en_n | input | 1 | Primary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low; high inserts a wait state |
| order_il | input | 1 | 1 = interleaved order, 0 = linear order; static |
| cur_addr | output | ADDR_W | Current internal burst address |
| loaded | output | 1 | A load happened on the last edge |
| advanced | output | 1 | An advance happened on the last edge |

## Verification
A wrong beat counter or capture register shows up on `cur_addr` one cycle after the faulty edge. The flags go wrong at the same time. A count that fails to clear on a new start shows up as a wrong low-bit pair on the very first beat after the strobe. A dropped or extra advance shows up on the next compare, and the error persists until the next load. The reference model replays every offset in both orders, with wraps, stalls and interrupts, and is compared on every cycle, so no such error can be masked by a later beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  parameter int BURST_BITS = 2;
  localparam int BEATS = 1 << BURST_BITS;
  typedef logic [BURST_BITS-1:0] beat_t;
endpackage

// File: rtl/bseq_ctl.sv
module bseq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_start_n,
  input  logic ctl_start_n,
  input  logic chip_en_n,
  input  logic adv_n,
  output logic load_now,
  output logic step_now,
  output logic loaded_q,
  output logic advanced_q
);
  logic cpu_take;
  logic hold_q;

  assign cpu_take = !cpu_start_n && !chip_en_n;
  assign load_now = cpu_take || !ctl_start_n;
  assign step_now = !load_now && !adv_n && !hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      loaded_q   <= 1'b0;
      advanced_q <= 1'b0;
    end else begin
      hold_q     <= cpu_take;
      loaded_q   <= load_now;
      advanced_q <= step_now;
    end
  end

  // R7: no advance on the edge following a processor-strobe load
  p_cpu_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && ctl_start_n && !(cpu_take)) |=> !advanced_q);
  // R5: gated processor strobe alone never loads
  p_cpu_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en_n && ctl_start_n) |=> !loaded_q);
  // R10: flags mutually exclusive
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loaded_q, advanced_q}));
endmodule

// File: rtl/bseq_count.sv
module bseq_count
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_now,
  input  logic  step_now,
  output beat_t count_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        count_q <= '0;
    else if (load_now) count_q <= '0;
    else if (step_now) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import burst_seq_pkg::*;
(
  input  beat_t start_bits,
  input  beat_t count,
  input  logic  interleave,
  output beat_t offset
);
  beat_t lin_off;
  beat_t il_off;

  assign lin_off = start_bits + count;

  for (genvar b = 0; b < BURST_BITS; b++) begin : g_xor
    assign il_off[b] = start_bits[b] ^ count[b];
  end

  assign offset = interleave ? il_off : lin_off;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              cpu_start_n,
  input  logic              ctl_start_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              order_il,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              loaded,
  output logic              advanced
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  logic              load_now;
  logic              step_now;
  logic [ADDR_W-1:0] base_q;
  beat_t             count_q;
  beat_t             offset;

  bseq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cpu_start_n(cpu_start_n),
    .ctl_start_n(ctl_start_n), .chip_en_n(chip_en_n), .adv_n(adv_n),
    .load_now(load_now), .step_now(step_now),
    .loaded_q(loaded), .advanced_q(advanced)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        base_q <= '0;
    else if (load_now) base_q <= ext_addr;
  end

  bseq_count u_count (
    .clk(clk), .rst_n(rst_n), .load_now(load_now),
    .step_now(step_now), .count_q(count_q)
  );

  bseq_order u_order (
    .start_bits(base_q[BURST_BITS-1:0]), .count(count_q),
    .interleave(order_il), .offset(offset)
  );

  assign cur_addr = {base_q[ADDR_W-1:BURST_BITS], offset};

  // R4: a load presents the captured address unchanged
  p_load_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> cur_addr == $past(ext_addr));
  // R3: upper bits stay put without a load
  p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> $stable(cur_addr[ADDR_W-1:BURST_BITS]));
  // R6: wait state keeps the address
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded && !advanced && $stable(order_il)) |-> $stable(cur_addr));
  // R1: linear advance steps the low bits by one
  p_lin_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (advanced && !order_il && $stable(order_il)) |->
      cur_addr[BURST_BITS-1:0] == beat_t'($past(cur_addr[BURST_BITS-1:0]) + 1'b1));

  initial begin
    assert (HI_W >= 1);
  end
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          cpu_start_n, ctl_start_n, chip_en_n, adv_n, order_il;
  logic [AW-1:0] cur_addr;
  logic          loaded, advanced;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  int m_base = 0;
  int m_cnt = 0;
  bit m_hold = 0;
  bit m_ld = 0;
  bit m_adv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .cpu_start_n(cpu_start_n),
    .ctl_start_n(ctl_start_n), .chip_en_n(chip_en_n), .adv_n(adv_n),
    .order_il(order_il), .cur_addr(cur_addr), .loaded(loaded), .advanced(advanced)
  );

  function automatic int exp_addr();
    int lo, s, off;
    s  = m_base % 4;
    lo = m_cnt % 4;
    off = order_il ? (s ^ lo) : ((s + lo) % 4);
    return (m_base - s) + off;
  endfunction

  task automatic compare(string tag);
    int ea;
    ea = exp_addr();
    vectors++;
    if (cur_addr !== AW'(ea) || loaded !== m_ld || advanced !== m_adv) begin
      misses++;
      $display("FAIL %s: addr=%05h ld=%0b adv=%0b expected addr=%05h ld=%0b adv=%0b",
               tag, cur_addr, loaded, advanced, ea, m_ld, m_adv);
    end
  endtask

  task automatic step(string tag, bit sp, bit sc, bit ce, bit av, int ea);
    bit take;
    cpu_start_n = sp; ctl_start_n = sc; chip_en_n = ce; adv_n = av;
    ext_addr = AW'(ea);
    @(posedge clk);
    take = !sp && !ce;
    if (take || !sc) begin
      m_base = ea; m_cnt = 0; m_ld = 1; m_adv = 0;
    end else if (!av && !m_hold) begin
      m_cnt++; m_ld = 0; m_adv = 1;
    end else begin
      m_ld = 0; m_adv = 0;
    end
    m_hold = take;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ext_addr = '0; cpu_start_n = 1; ctl_start_n = 1;
    chip_en_n = 1; adv_n = 1; order_il = 0;
    repeat (3) @(negedge clk);
    compare("R9 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R9 after reset");

    for (int md = 0; md < 2; md++) begin
      order_il = md[0];
      for (int s = 0; s < 4; s++) begin
        int a = 32'h5A3C0 + (md * 32'h1110) + s;
        step("R4 ctl load", 1, 0, 1, 1, 0);
        m_base = 0;
        step(md ? "R4" : "R4", 1, 0, 1, 1, a);
        for (int k = 0; k < 3; k++) step(md ? "R2 beat" : "R1 beat", 1, 1, 1, 0, 0);
        step("R6 stall", 1, 1, 1, 1, 0);
        step("R6 stall", 1, 1, 0, 1, 0);
        step("R8 wrap", 1, 1, 1, 0, 0);
        step("R8 wrap", 1, 1, 1, 0, 0);
        step("R3 upper", 1, 1, 1, 0, 32'hFFFFF);
      end
      // processor start with adv low: first edge must not advance
      step("R5 cpu load", 0, 1, 0, 0, 32'h12346);
      step("R7 no advance", 1, 1, 0, 0, 0);
      step("R7 then advance", 1, 1, 0, 0, 0);
      // gated processor strobe ignored
      step("R5 gated", 0, 1, 1, 1, 32'hABCDE);
      step("R5 gated adv", 0, 1, 1, 0, 32'hABCDF);
      // interrupt mid-burst with controller strobe
      step("R4 interrupt", 1, 0, 1, 0, 32'h0F0F3);
      step("R10 beat", 1, 1, 1, 0, 0);
      // interrupt with processor strobe during a burst
      step("R5 interrupt", 0, 1, 0, 0, 32'h77771);
      step("R7 hold", 1, 1, 1, 0, 0);
      step("R10 beat", 1, 1, 1, 0, 0);
      // both strobes at once still load
      step("R4 both", 0, 0, 0, 0, 32'h33332);
      step("R7 hold both", 1, 1, 1, 0, 0);
    end

    rst_n = 0;
    m_base = 0; m_cnt = 0; m_hold = 0; m_ld = 0; m_adv = 0;
    @(negedge clk);
    compare("R9 second reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule